// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block conditions the external interrupt pins and the key-scan pins of a small microcontroller. Every pin is synchronized to the core clock, filtered for a minimum stable width, and then passed to an edge detector whose rule depends on the source. Two vectored sources each have a trigger edge chosen by software, either rising or falling. A third vectored source fires on every edge. A quasi-interrupt source fires only on a rising edge. A bank of key-scan pins fires on falling edges. Quasi-interrupts only raise a flag and never present a vectored request.

A detected edge sets a sticky flag. The flag stays set until software writes a one to its clear bit. Enabled flags drive the vectored request outputs and a wake output, and the wake output can end a stop or idle power-down state. A disabled source still records its flag, so enabling it later shows a request that is already pending. The key-scan flags are reported one bit per pin, and their OR forms a single quasi flag.

Software talks to the block through a small write port. Address 0 holds the edge selects, address 1 the enables, address 2 the flag clears, and address 3 the per-key clears.

Top module: `irq_edge_detect`

## Requirements
- R1: After reset, `irq_o`, `quasi_o`, `key_stat_o` and `wake_o` are all zero. All edge selects reset to rising (0) and all enables reset to off.
- R2: A pin level must hold for at least FILT_CYC consecutive clock cycles after synchronization to be recognized. A level held for FILT_CYC-1 cycles or fewer sets no flag.
- R3: Address 0 bit 0 selects the edge for source A and bit 1 selects it for source B. A value of 0 means a rising edge sets the flag and 1 means a falling edge sets it. The edge of the other direction is ignored.
- R4: Writing a new edge select while the pin is held steady creates no request.
- R5: Source DUAL (`irq_o[2]`) sets its flag on both rising and falling edges.
- R6: Source QRISE sets `quasi_o[0]` on a rising edge only. A falling edge has no effect.
- R7: Each key pin k sets `key_stat_o[k]` on a falling edge only. `quasi_o[1]` is the OR of `key_stat_o`.
- R8: Flags are sticky. A write to address 2 clears the flags whose bits are one: bit 0 clears A, bit 1 clears B, bit 2 clears DUAL, bit 3 clears QRISE, and bit 4 clears all key bits. A write to address 3 clears the key bits given one per pin. Bits written as zero leave their flags unchanged.
- R9: Address 1 holds the enables: bit 0 for A, bit 1 for B, bit 2 for DUAL, bit 3 for QRISE and bit 4 for the keys. `irq_o` bits 0, 1 and 2 show the flags of A, B and DUAL gated by their enables. A flag set while its source is disabled is kept, and it appears once the source is enabled.
- R10: `wake_o` is high exactly when at least one flag is set and its source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_pin_i | input | 2 | Raw pins of vectored sources A (bit 0) and B (bit 1) |
| dual_pin_i | input | 1 | Raw pin of the both-edge vectored source |
| qrise_pin_i | input | 1 | Raw pin of the rising-edge quasi source |
| key_pin_i | input | NKEY | Raw key-scan pins, idle high |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_addr_i | input | 2 | Control address (0 select, 1 enable, 2 clear, 3 key clear) |
| ctl_wdata_i | input | max(NKEY,5) | Control write data |
| irq_o | output | 3 | Enabled vectored requests: A, B, DUAL |
| quasi_o | output | 2 | Quasi flags: QRISE (bit 0), any key (bit 1) |
| key_stat_o | output | NKEY | Per-key falling-edge status |
| wake_o | output | 1 | Power-down exit request |

## Verification
The assertions assume that the pins and the control strobe are steady around the sampling edge, and that idle key pins sit high before reset is released. The assertion on the filter also assumes that a level shorter than the filter window never reaches the edge detector. The stimulus drives every pin and control write on the falling clock edge. Each toggle or write is then held for several filter windows before the outputs are sampled, so every event settles completely. Short pulses appear only in the directed tests of the filter.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  typedef enum logic [1:0] {EDGE_RISE, EDGE_FALL, EDGE_BOTH, EDGE_SEL} edge_mode_e;

  localparam int SRC_A     = 0;
  localparam int SRC_B     = 1;
  localparam int SRC_DUAL  = 2;
  localparam int SRC_QRISE = 3;
  localparam int NFIX      = 4;

  localparam logic [1:0] ADDR_SEL  = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [1:0] ADDR_KCLR = 2'd3;
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int   FILT_CYC = 40,
  parameter logic IDLE     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC - 1);

  logic s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= IDLE;
      s2_q   <= IDLE;
      filt_q <= IDLE;
      cnt_q  <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_MAX) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = filt_q;

  // R2
  filt_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CNT_MAX && $past(s2_q) == filt_q));
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_edge_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE,
  parameter logic       IDLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  localparam logic IDLE_ADJ = (MODE == EDGE_FALL) ? ~IDLE : IDLE;

  logic adj, prev_q, sel_q, sel_chg;

  always_comb begin
    case (MODE)
      EDGE_FALL: adj = ~lvl_i;
      EDGE_SEL:  adj = lvl_i ^ fall_sel_i;
      default:   adj = lvl_i;
    endcase
  end

  // select change reloads prev_q and masks the cycle
  assign sel_chg = (MODE == EDGE_SEL) && (fall_sel_i != sel_q);
  assign edge_o  = (MODE == EDGE_BOTH) ? (adj ^ prev_q) : (adj & ~prev_q & ~sel_chg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= IDLE_ADJ;
      sel_q  <= 1'b0;
    end else begin
      prev_q <= adj;
      sel_q  <= fall_sel_i;
    end
  end

  // R4
  sel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == EDGE_SEL && edge_o) |-> $stable(fall_sel_i));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flg_o
);
  logic [N-1:0] flg_q;

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_i) | set_i;
  end

  assign flg_o = flg_q;

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~flg_q) == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flg_q & ~clr_i) & ~flg_q) == '0));

  // R8
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flg_q & ~$past(flg_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
  import irq_edge_pkg::*;
#(
  parameter  int NKEY     = 8,
  parameter  int FILT_CYC = 40,
  localparam int DW       = (NKEY > 5) ? NKEY : 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      sel_pin_i,
  input  logic            dual_pin_i,
  input  logic            qrise_pin_i,
  input  logic [NKEY-1:0] key_pin_i,
  input  logic            ctl_we_i,
  input  logic [1:0]      ctl_addr_i,
  input  logic [DW-1:0]   ctl_wdata_i,
  output logic [2:0]      irq_o,
  output logic [1:0]      quasi_o,
  output logic [NKEY-1:0] key_stat_o,
  output logic            wake_o
);
  localparam int NFLG = NFIX + NKEY;

  logic [1:0]      sel_q;
  logic [4:0]      en_q;
  logic [NFLG-1:0] pin_all, lvl_all, edge_all, fsel_all, clr_all, flg;
  logic [NKEY-1:0] clr_key;
  logic [3:0]      clr_fix;
  logic            key_any;

  assign pin_all  = {key_pin_i, qrise_pin_i, dual_pin_i, sel_pin_i};
  assign fsel_all = NFLG'(sel_q);

  for (genvar i = 0; i < NFLG; i++) begin : g_src
    localparam logic IDL = (i >= NFIX) ? 1'b1 : 1'b0;
    localparam edge_mode_e M = (i < 2)         ? EDGE_SEL  :
                               (i == SRC_DUAL) ? EDGE_BOTH :
                               (i == SRC_QRISE)? EDGE_RISE : EDGE_FALL;
    irq_pin_cond #(.FILT_CYC(FILT_CYC), .IDLE(IDL)) u_cond (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_all[i]),
      .lvl_o (lvl_all[i])
    );
    irq_edge_det #(.MODE(M), .IDLE(IDL)) u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl_all[i]),
      .fall_sel_i(fsel_all[i]),
      .edge_o    (edge_all[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= '0;
    end else if (ctl_we_i) begin
      if (ctl_addr_i == ADDR_SEL) sel_q <= ctl_wdata_i[1:0];
      if (ctl_addr_i == ADDR_EN)  en_q  <= ctl_wdata_i[4:0];
    end
  end

  always_comb begin
    clr_fix = '0;
    clr_key = '0;
    if (ctl_we_i && ctl_addr_i == ADDR_CLR) begin
      clr_fix = ctl_wdata_i[3:0];
      if (ctl_wdata_i[4]) clr_key = '1;
    end
    if (ctl_we_i && ctl_addr_i == ADDR_KCLR) clr_key = ctl_wdata_i[NKEY-1:0];
  end

  assign clr_all = {clr_key, clr_fix};

  irq_flag_bank #(.N(NFLG)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (edge_all),
    .clr_i (clr_all),
    .flg_o (flg)
  );

  assign key_stat_o = flg[NFLG-1:NFIX];
  assign key_any    = |key_stat_o;
  assign quasi_o    = {key_any, flg[SRC_QRISE]};
  assign irq_o      = flg[2:0] & en_q[2:0];
  assign wake_o     = (|irq_o) | (flg[SRC_QRISE] & en_q[3]) | (key_any & en_q[4]);

  // R9
  irq_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) != 3'b000 && !$past(ctl_we_i)) |-> ((irq_o & $past(irq_o)) == $past(irq_o)));
endmodule

// File: tb/tb_irq_edge_detect.sv
module tb_irq_edge_detect;
  localparam int CLK_P = 10;
  localparam int NK    = 8;
  localparam int FC    = 4;
  localparam int NF    = 4 + NK;
  localparam int SETTLE = FC + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] p;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [NK-1:0] wdata = '0;
  logic [2:0] irq;
  logic [1:0] quasi;
  logic [NK-1:0] kst;
  logic wake;

  int checks = 0, fails = 0;
  logic [3:0] mf;
  logic [NK-1:0] mk;
  logic [4:0] men;
  logic [1:0] msel;

  always #(CLK_P/2) clk = ~clk;

  irq_edge_detect #(.NKEY(NK), .FILT_CYC(FC)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_pin_i(p[1:0]), .dual_pin_i(p[2]), .qrise_pin_i(p[3]),
    .key_pin_i(p[NF-1:4]),
    .ctl_we_i(we), .ctl_addr_i(addr), .ctl_wdata_i(wdata),
    .irq_o(irq), .quasi_o(quasi), .key_stat_o(kst), .wake_o(wake)
  );

  function automatic logic [2:0] e_irq();
    return mf[2:0] & men[2:0];
  endfunction
  function automatic logic [1:0] e_quasi();
    return {|mk, mf[3]};
  endfunction
  function automatic logic e_wake();
    return (|e_irq()) | (mf[3] & men[3]) | ((|mk) & men[4]);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_all();
    chk(irq == e_irq(), "R9 irq", 32'(irq), 32'(e_irq()));
    chk(quasi == e_quasi(), "R6 quasi", 32'(quasi), 32'(e_quasi()));
    chk(kst == mk, "R7 keys", 32'(kst), 32'(mk));
    chk(wake == e_wake(), "R10 wake", 32'(wake), 32'(e_wake()));
  endtask

  task automatic wr(input logic [1:0] a, input logic [NK-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      2'd0: msel = d[1:0];
      2'd1: men = d[4:0];
      2'd2: begin mf = mf & ~d[3:0]; if (d[4]) mk = '0; end
      default: mk = mk & ~d;
    endcase
    tick(3);
  endtask

  task automatic tog(input int idx);
    logic o, n;
    o = p[idx]; n = ~o;
    p[idx] = n;
    if (idx < 2) begin
      if ((msel[idx] && o && !n) || (!msel[idx] && !o && n)) mf[idx] = 1'b1;
    end else if (idx == 2) mf[2] = 1'b1;
    else if (idx == 3) begin if (n) mf[3] = 1'b1; end
    else if (!n) mk[idx-4] = 1'b1;
    tick(SETTLE);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1a2b);
    p = {{NK{1'b1}}, 4'b0000};
    mf = '0; mk = '0; men = '0; msel = '0;
    tick(4);
    rst_n = 1'b1;
    tick(SETTLE);
    // R1 reset state
    chk(irq == 3'b0 && quasi == 2'b0 && kst == '0 && wake == 1'b0, "R1 reset",
        {irq, quasi, wake}, 32'h0);
    cmp_all();

    wr(2'd1, 8'h1f);
    // R3 rising select on A
    tog(0);
    chk(irq[0] == 1'b1, "R3 rise A", 32'(irq[0]), 32'h1);
    wr(2'd2, 8'h01);
    tog(0);
    chk(irq[0] == 1'b0, "R3 fall ignored A", 32'(irq[0]), 32'h0);
    wr(2'd0, 8'h01);
    tog(0);
    chk(irq[0] == 1'b0, "R3 rise ignored A", 32'(irq[0]), 32'h0);
    tog(0);
    chk(irq[0] == 1'b1, "R3 fall A", 32'(irq[0]), 32'h1);
    wr(2'd2, 8'h01);

    // R4 select change with B high
    tog(1);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    chk(irq[1] == 1'b0, "R4 select change", 32'(irq[1]), 32'h0);
    cmp_all();

    // R5 both edges
    tog(2);
    chk(irq[2] == 1'b1, "R5 dual rise", 32'(irq[2]), 32'h1);
    wr(2'd2, 8'h04);
    tog(2);
    chk(irq[2] == 1'b1, "R5 dual fall", 32'(irq[2]), 32'h1);
    wr(2'd2, 8'h04);

    // R2 filter boundary
    @(negedge clk); p[2] = 1'b1; tick(FC - 1); p[2] = 1'b0; tick(SETTLE);
    chk(irq[2] == 1'b0, "R2 short pulse", 32'(irq[2]), 32'h0);
    @(negedge clk); p[2] = 1'b1; tick(FC); p[2] = 1'b0; tick(SETTLE);
    chk(irq[2] == 1'b1, "R2 full pulse", 32'(irq[2]), 32'h1);
    mf[2] = 1'b1;
    wr(2'd2, 8'h04);

    // R6 quasi rising only
    tog(3);
    chk(quasi[0] == 1'b1, "R6 qrise", 32'(quasi[0]), 32'h1);
    wr(2'd2, 8'h08);
    tog(3);
    chk(quasi[0] == 1'b0, "R6 fall ignored", 32'(quasi[0]), 32'h0);

    // R7 key falling
    tog(4 + 5);
    chk(kst == 8'h20 && quasi[1] == 1'b1, "R7 key5 fall", 32'({quasi[1], kst}), 32'h120);
    tog(4 + 5);
    chk(kst == 8'h20, "R7 key rise ignored", 32'(kst), 32'h20);
    tog(4 + 2);
    // R8 per-key clear
    wr(2'd3, 8'h20);
    chk(kst == 8'h04, "R8 key clear", 32'(kst), 32'h04);
    wr(2'd2, 8'h10);
    chk(kst == 8'h00 && quasi[1] == 1'b0, "R8 all key clear", 32'(kst), 32'h0);

    // R9 disabled flag kept
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    tog(0);
    chk(irq[0] == 1'b0 && wake == 1'b0, "R9 masked", 32'({irq[0], wake}), 32'h0);
    wr(2'd1, 8'h01);
    chk(irq[0] == 1'b1 && wake == 1'b1, "R10 wake after enable", 32'({irq[0], wake}), 32'h3);
    wr(2'd2, 8'h1f);
    cmp_all();

    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6) tog(int'($urandom_range(0, NF - 1)));
      else if (op == 6) wr(2'd1, NK'($urandom_range(0, 31)));
      else if (op == 7) wr(2'd2, NK'($urandom_range(0, 31)));
      else if (op == 8) wr(2'd3, NK'($urandom));
      else wr(2'd0, NK'($urandom_range(0, 3)));
      cmp_all();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule